// File: doc/BRIEF.md
# Program Counter Sequencer with Hardware Repeat and Breakpoint

This block holds the word-addressed program counter of a small processor core and decides its next value on every instruction step. The next value comes from one priority decision: bus-error and illegal-instruction events, an instruction-address breakpoint, a taken branch, the loop-back of a zero-overhead repeat loop, and plain sequential advance. Instruction execution happens elsewhere. The core supplies a step strobe, the branch outcome, the loop bounds and the breakpoint address, and reads back the PC, the byte fetch address, the status word, the repeat count and the backup registers.

A repeat loop is armed by loading the count and setting the repeat flag in the status word through the write ports while no step is in progress. When the instruction at the loop-end address retires, the sequencer either jumps back to the loop start and decrements the count, or leaves the loop and clears the flag. A redirect to any of the three trap vectors saves the current PC and status into backup registers in the same cycle.

Status bits used by the sequencer: stack mode is bit 15, debug enable is bit 12, repeat active is bit 7, flag F0 is bit 3, flag F1 is bit 2, carry is bit 0.

Top module: `pc_seq`

## Requirements
- R1: After reset the PC is 0xFFC0, the fetch address is 0x3FF00, and the status word, repeat count and both backup registers are zero.
- R2: A step with no event, branch or loop hit advances the PC by one, wrapping from 0xFFFF to 0x0000.
- R3: The fetch address always equals the PC shifted left by two, with the two low bits zero.
- R4: A step at the loop-end address with repeat active (bit 7), no taken branch and a count above 1 loads the loop start into the PC and decrements the count, keeping bit 7 set.
- R5: A step at the loop-end address with repeat active, no taken branch and a count of 1 or 0 clears bit 7, advances the PC by one and leaves the count unchanged.
- R6: A taken branch loads the branch target, and at the loop-end address it wins over the loop-back, leaving the count and bit 7 unchanged.
- R7: A step whose PC equals the breakpoint address while debug enable (bit 12) is set jumps to the debug vector 0x3FF4, keeps only the stack-mode bit (bit 15) of the status word, leaves the count unchanged and saves the old PC and status into the backup registers; it overrides a taken branch and a loop-back.
- R8: A step with a bus error jumps to vector 0x3FEC, keeps only F0, F1 and carry (bits 3, 2, 0) of the status word, saves PC and status into the backups, and takes priority over a breakpoint.
- R9: A step with an illegal-instruction event and no bus error jumps to vector 0x3FEE with the same status masking and backup save; with both events the bus-error vector is taken.
- R10: Without a step the PC, status and count hold, except that the status and count write ports load their data; those writes are ignored in a cycle with a step.
- R11: With bit 7 clear, the loop-end address has no effect on sequencing; with bit 12 clear, the breakpoint address has no effect.
- R12: The backup write strobe is high exactly in a step cycle that takes an error or breakpoint redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One instruction retires this cycle |
| br_taken_i | input | 1 | The retiring instruction branches |
| br_target_i | input | 16 | Branch target word address |
| rpt_start_i | input | 16 | Loop start word address |
| rpt_end_i | input | 16 | Loop end word address |
| bp_addr_i | input | 16 | Breakpoint word address |
| bus_err_i | input | 1 | Bus error on the retiring instruction |
| ill_err_i | input | 1 | Illegal instruction event |
| psw_wr_i | input | 1 | Status word write strobe |
| psw_wdata_i | input | 16 | Status word write data |
| cnt_wr_i | input | 1 | Repeat count write strobe |
| cnt_wdata_i | input | 16 | Repeat count write data |
| pc_o | output | 16 | Current word PC |
| fetch_addr_o | output | 18 | Byte fetch address |
| psw_o | output | 16 | Status word |
| rpt_cnt_o | output | 16 | Repeat count |
| bk_pc_o | output | 16 | Saved PC |
| bk_psw_o | output | 16 | Saved status word |
| bk_we_o | output | 1 | Backup write strobe this cycle |

## Verification
The assertions check the outcome of each individual step against the ports: the vector and status mask of each trap, the breakpoint override, branch priority, loop-back with decrement, loop exit, sequential advance, idle hold and the backup save. Only the bench scenarios show whole loops running for their full count and exiting, the interplay of count writes of 0 and 1 with the exit rule, PC wrap-around, writes ignored during a step, and the combined-event priority orderings over a sequence of steps.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int PSW_W  = 16;
  localparam int SM_BIT = 15;
  localparam int DB_BIT = 12;
  localparam int RP_BIT = 7;
  localparam int F0_BIT = 3;
  localparam int F1_BIT = 2;
  localparam int C_BIT  = 0;

  localparam logic [PSW_W-1:0] ERR_KEEP =
    PSW_W'((1 << F0_BIT) | (1 << F1_BIT) | (1 << C_BIT));
  localparam logic [PSW_W-1:0] DBG_KEEP = PSW_W'(1 << SM_BIT);

  typedef enum logic [2:0] {
    NXT_SEQ,
    NXT_LOOP,
    NXT_EXIT,
    NXT_BRANCH,
    NXT_DEBUG,
    NXT_BUS,
    NXT_ILL
  } nxt_sel_e;
endpackage

// File: rtl/pc_seq_loop.sv
module pc_seq_loop #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  end_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rp_i,
  input  logic             br_taken_i,
  output logic             loop_back_o,
  output logic             loop_exit_o,
  output logic [CNT_W-1:0] cnt_dec_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_end;
  logic last_pass;

  assign at_end      = rp_i && (pc_i == end_i) && !br_taken_i;
  // count of zero behaves as one
  assign last_pass   = (cnt_i <= ONE);
  assign loop_back_o = at_end && !last_pass;
  assign loop_exit_o = at_end && last_pass;
  assign cnt_dec_o   = cnt_i - ONE;
endmodule

// File: rtl/pc_seq_trap.sv
module pc_seq_trap
  import pc_seq_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            bus_err_i,
  input  logic            ill_err_i,
  input  logic            db_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] bp_addr_i,
  input  logic            br_taken_i,
  input  logic            loop_back_i,
  input  logic            loop_exit_i,
  output nxt_sel_e        sel_o,
  output logic            trap_o
);
  logic bp_hit;

  assign bp_hit = db_i && (pc_i == bp_addr_i);

  always_comb begin
    if (bus_err_i)        sel_o = NXT_BUS;
    else if (ill_err_i)   sel_o = NXT_ILL;
    else if (bp_hit)      sel_o = NXT_DEBUG;
    else if (br_taken_i)  sel_o = NXT_BRANCH;
    else if (loop_back_i) sel_o = NXT_LOOP;
    else if (loop_exit_i) sel_o = NXT_EXIT;
    else                  sel_o = NXT_SEQ;
  end

  assign trap_o = bus_err_i || ill_err_i || bp_hit;
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter int              CNT_W    = 16,
  parameter logic [PC_W-1:0] RESET_PC = PC_W'('hFFC0),
  parameter logic [PC_W-1:0] BUS_VEC  = PC_W'('h3FEC),
  parameter logic [PC_W-1:0] ILL_VEC  = PC_W'('h3FEE),
  parameter logic [PC_W-1:0] DBG_VEC  = PC_W'('h3FF4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              br_taken_i,
  input  logic [PC_W-1:0]   br_target_i,
  input  logic [PC_W-1:0]   rpt_start_i,
  input  logic [PC_W-1:0]   rpt_end_i,
  input  logic [PC_W-1:0]   bp_addr_i,
  input  logic              bus_err_i,
  input  logic              ill_err_i,
  input  logic              psw_wr_i,
  input  logic [PSW_W-1:0]  psw_wdata_i,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W+1:0]   fetch_addr_o,
  output logic [PSW_W-1:0]  psw_o,
  output logic [CNT_W-1:0]  rpt_cnt_o,
  output logic [PC_W-1:0]   bk_pc_o,
  output logic [PSW_W-1:0]  bk_psw_o,
  output logic              bk_we_o
);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic [PC_W-1:0]  pc_q, pc_d;
  logic [PSW_W-1:0] psw_q, psw_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_dec;
  logic [PC_W-1:0]  bk_pc_q;
  logic [PSW_W-1:0] bk_psw_q;
  logic             loop_back, loop_exit, trap;
  nxt_sel_e         sel;

  pc_seq_loop #(.PC_W(PC_W), .CNT_W(CNT_W)) u_loop (
    .pc_i        (pc_q),
    .end_i       (rpt_end_i),
    .cnt_i       (cnt_q),
    .rp_i        (psw_q[RP_BIT]),
    .br_taken_i  (br_taken_i),
    .loop_back_o (loop_back),
    .loop_exit_o (loop_exit),
    .cnt_dec_o   (cnt_dec)
  );

  pc_seq_trap #(.PC_W(PC_W)) u_trap (
    .bus_err_i   (bus_err_i),
    .ill_err_i   (ill_err_i),
    .db_i        (psw_q[DB_BIT]),
    .pc_i        (pc_q),
    .bp_addr_i   (bp_addr_i),
    .br_taken_i  (br_taken_i),
    .loop_back_i (loop_back),
    .loop_exit_i (loop_exit),
    .sel_o       (sel),
    .trap_o      (trap)
  );

  always_comb begin
    pc_d  = pc_q;
    psw_d = psw_q;
    cnt_d = cnt_q;
    if (step_i) begin
      unique case (sel)
        NXT_BUS: begin
          pc_d  = BUS_VEC;
          psw_d = psw_q & ERR_KEEP;
        end
        NXT_ILL: begin
          pc_d  = ILL_VEC;
          psw_d = psw_q & ERR_KEEP;
        end
        NXT_DEBUG: begin
          pc_d  = DBG_VEC;
          psw_d = psw_q & DBG_KEEP;
        end
        NXT_BRANCH: pc_d = br_target_i;
        NXT_LOOP: begin
          pc_d  = rpt_start_i;
          cnt_d = cnt_dec;
        end
        NXT_EXIT: begin
          pc_d          = pc_q + PC_ONE;
          psw_d[RP_BIT] = 1'b0;
        end
        default: pc_d = pc_q + PC_ONE;
      endcase
    end else begin
      if (psw_wr_i) psw_d = psw_wdata_i;
      if (cnt_wr_i) cnt_d = cnt_wdata_i;
    end
  end

  assign bk_we_o = step_i && trap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= RESET_PC;
      psw_q    <= '0;
      cnt_q    <= '0;
      bk_pc_q  <= '0;
      bk_psw_q <= '0;
    end else begin
      pc_q  <= pc_d;
      psw_q <= psw_d;
      cnt_q <= cnt_d;
      if (bk_we_o) begin
        bk_pc_q  <= pc_q;
        bk_psw_q <= psw_q;
      end
    end
  end

  assign pc_o         = pc_q;
  assign fetch_addr_o = {pc_q, 2'b00};
  assign psw_o        = psw_q;
  assign rpt_cnt_o    = cnt_q;
  assign bk_pc_o      = bk_pc_q;
  assign bk_psw_o     = bk_psw_q;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk
  import pc_seq_pkg::*;
#(
  parameter int              PC_W    = 16,
  parameter int              CNT_W   = 16,
  parameter logic [PC_W-1:0] BUS_VEC = PC_W'('h3FEC),
  parameter logic [PC_W-1:0] ILL_VEC = PC_W'('h3FEE),
  parameter logic [PC_W-1:0] DBG_VEC = PC_W'('h3FF4)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic             br_taken_i,
  input logic [PC_W-1:0]  br_target_i,
  input logic [PC_W-1:0]  rpt_start_i,
  input logic [PC_W-1:0]  rpt_end_i,
  input logic [PC_W-1:0]  bp_addr_i,
  input logic             bus_err_i,
  input logic             ill_err_i,
  input logic             psw_wr_i,
  input logic             cnt_wr_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [PSW_W-1:0] psw_o,
  input logic [CNT_W-1:0] rpt_cnt_o,
  input logic [PC_W-1:0]  bk_pc_o,
  input logic [PSW_W-1:0] bk_psw_o,
  input logic             bk_we_o
);
  logic no_err, bp_hit, at_end, plain;

  assign no_err = !bus_err_i && !ill_err_i;
  assign bp_hit = psw_o[DB_BIT] && (pc_o == bp_addr_i);
  assign at_end = psw_o[RP_BIT] && (pc_o == rpt_end_i);
  assign plain  = step_i && no_err && !bp_hit && !br_taken_i;

  AST_ERR_BUS_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && bus_err_i |=> pc_o == BUS_VEC && psw_o == ($past(psw_o) & ERR_KEEP)); // R8

  AST_ERR_ILL_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !bus_err_i && ill_err_i |=> pc_o == ILL_VEC && psw_o == ($past(psw_o) & ERR_KEEP)); // R9

  AST_BKPT_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && no_err && bp_hit |=> pc_o == DBG_VEC && psw_o == ($past(psw_o) & DBG_KEEP)
      && $stable(rpt_cnt_o)); // R7

  AST_BK_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bk_we_o |=> bk_pc_o == $past(pc_o) && bk_psw_o == $past(psw_o)); // R7

  AST_BK_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |-> !bk_we_o); // R12

  AST_BRANCH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && no_err && !bp_hit && br_taken_i |=> pc_o == $past(br_target_i)
      && $stable(rpt_cnt_o) && $stable(psw_o)); // R6

  AST_LOOP_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain && at_end && rpt_cnt_o > CNT_W'(1) |=> pc_o == $past(rpt_start_i)
      && rpt_cnt_o == $past(rpt_cnt_o) - CNT_W'(1) && psw_o[RP_BIT]); // R4

  AST_LOOP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain && at_end && rpt_cnt_o <= CNT_W'(1) |=> pc_o == $past(pc_o) + PC_W'(1)
      && !psw_o[RP_BIT] && $stable(rpt_cnt_o)); // R5

  AST_SEQ_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain && !at_end |=> pc_o == $past(pc_o) + PC_W'(1) && $stable(psw_o)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !psw_wr_i && !cnt_wr_i |=> $stable(pc_o) && $stable(psw_o)
      && $stable(rpt_cnt_o)); // R10
endmodule

bind pc_seq pc_seq_chk #(
  .PC_W(PC_W), .CNT_W(CNT_W), .BUS_VEC(BUS_VEC), .ILL_VEC(ILL_VEC), .DBG_VEC(DBG_VEC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_i      (step_i),
  .br_taken_i  (br_taken_i),
  .br_target_i (br_target_i),
  .rpt_start_i (rpt_start_i),
  .rpt_end_i   (rpt_end_i),
  .bp_addr_i   (bp_addr_i),
  .bus_err_i   (bus_err_i),
  .ill_err_i   (ill_err_i),
  .psw_wr_i    (psw_wr_i),
  .cnt_wr_i    (cnt_wr_i),
  .pc_o        (pc_o),
  .psw_o       (psw_o),
  .rpt_cnt_o   (rpt_cnt_o),
  .bk_pc_o     (bk_pc_o),
  .bk_psw_o    (bk_psw_o),
  .bk_we_o     (bk_we_o)
);

// File: tb/tb_pc_seq.sv
module tb_pc_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 0, br_taken_i = 0, bus_err_i = 0, ill_err_i = 0;
  logic        psw_wr_i = 0, cnt_wr_i = 0;
  logic [15:0] br_target_i = 0, rpt_start_i = 0, rpt_end_i = 0, bp_addr_i = 0;
  logic [15:0] psw_wdata_i = 0, cnt_wdata_i = 0;
  logic [15:0] pc_o, psw_o, rpt_cnt_o, bk_pc_o, bk_psw_o;
  logic [17:0] fetch_addr_o;
  logic        bk_we_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  int m_pc, m_psw, m_cnt, m_bkpc, m_bkpsw;

  localparam int SM = 15, DB = 12, RP = 7;

  always #5 clk_i = ~clk_i;

  pc_seq dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "pc", int'(pc_o), m_pc);
    chk("R3", "fetch", int'(fetch_addr_o), m_pc * 4);
    chk(tag, "psw", int'(psw_o), m_psw);
    chk(tag, "cnt", int'(rpt_cnt_o), m_cnt);
    chk(tag, "bk_pc", int'(bk_pc_o), m_bkpc);
    chk(tag, "bk_psw", int'(bk_psw_o), m_bkpsw);
  endtask

  // one clock: model next state from current inputs, then compare after the edge
  task automatic tick(input string tag);
    bit bp, trapv;
    int n_pc, n_psw, n_cnt, n_bkpc, n_bkpsw;
    #1;
    bp = m_psw[DB] && (m_pc == int'(bp_addr_i));
    trapv = step_i && (bus_err_i || ill_err_i || bp);
    chk("R12", "bk_we", int'(bk_we_o), int'(trapv));
    n_pc = m_pc; n_psw = m_psw; n_cnt = m_cnt; n_bkpc = m_bkpc; n_bkpsw = m_bkpsw;
    if (step_i) begin
      if (bus_err_i || ill_err_i) begin
        n_bkpc = m_pc; n_bkpsw = m_psw;
        n_psw = m_psw & 'h000D;
        n_pc = bus_err_i ? 'h3FEC : 'h3FEE;
      end else if (bp) begin
        n_bkpc = m_pc; n_bkpsw = m_psw;
        n_psw = m_psw & 'h8000;
        n_pc = 'h3FF4;
      end else if (br_taken_i) begin
        n_pc = int'(br_target_i);
      end else if (m_psw[RP] && m_pc == int'(rpt_end_i)) begin
        if (m_cnt <= 1) begin
          n_psw = m_psw & ~(1 << RP);
          n_pc = (m_pc + 1) & 'hFFFF;
        end else begin
          n_cnt = m_cnt - 1;
          n_pc = int'(rpt_start_i);
        end
      end else begin
        n_pc = (m_pc + 1) & 'hFFFF;
      end
    end else begin
      if (psw_wr_i) n_psw = int'(psw_wdata_i);
      if (cnt_wr_i) n_cnt = int'(cnt_wdata_i);
    end
    @(posedge clk_i);
    @(negedge clk_i);
    m_pc = n_pc; m_psw = n_psw; m_cnt = n_cnt; m_bkpc = n_bkpc; m_bkpsw = n_bkpsw;
    compare(tag);
    step_i = 0; br_taken_i = 0; bus_err_i = 0; ill_err_i = 0;
    psw_wr_i = 0; cnt_wr_i = 0;
  endtask

  task automatic step(input string tag);
    step_i = 1;
    tick(tag);
  endtask

  task automatic wr_psw(input int v);
    psw_wr_i = 1; psw_wdata_i = 16'(v);
    tick("R10");
  endtask

  task automatic wr_cnt(input int v);
    cnt_wr_i = 1; cnt_wdata_i = 16'(v);
    tick("R10");
  endtask

  task automatic branch(input string tag, input int t);
    step_i = 1; br_taken_i = 1; br_target_i = 16'(t);
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_pc = 'hFFC0; m_psw = 0; m_cnt = 0; m_bkpc = 0; m_bkpsw = 0;
    bp_addr_i = 16'h7777;
    repeat (3) @(negedge clk_i);
    compare("R1");
    rst_ni = 1;
    @(negedge clk_i);
    compare("R1");

    // R2: sequential steps from reset PC
    for (int i = 0; i < 4; i++) step("R2");
    // R10: idle cycles hold
    for (int i = 0; i < 3; i++) tick("R10");

    // R6: branch away from loop region
    branch("R6", 'h0010);
    // R4/R5: loop 0x10..0x12 with count 3
    rpt_start_i = 16'h0010; rpt_end_i = 16'h0012;
    wr_cnt(3);
    wr_psw(1 << RP);
    for (int i = 0; i < 10; i++) step("R4");
    chk("R5", "rp cleared after loop", int'(psw_o[RP]), 0);

    // R10: writes during a step are ignored
    step_i = 1; psw_wr_i = 1; psw_wdata_i = 16'hFFFF; cnt_wr_i = 1; cnt_wdata_i = 16'h1234;
    tick("R10");

    // R5: count 0 behaves as 1
    branch("R6", 'h0010);
    wr_cnt(0);
    wr_psw(1 << RP);
    for (int i = 0; i < 3; i++) step("R5");

    // R5: count 1
    branch("R6", 'h0011);
    wr_cnt(1);
    wr_psw(1 << RP);
    for (int i = 0; i < 2; i++) step("R5");

    // R6: branch at loop end wins
    branch("R6", 'h0012);
    wr_cnt(5);
    wr_psw(1 << RP);
    branch("R6", 'h0100);
    step("R2");

    // R11: loop end with repeat clear
    branch("R6", 'h0012);
    wr_psw(0);
    step("R11");

    // R7: breakpoint overrides branch
    bp_addr_i = 16'h0020;
    branch("R6", 'h0020);
    wr_psw((1 << SM) | (1 << DB) | (1 << RP) | 'h000F);
    rpt_end_i = 16'h0020;
    step_i = 1; br_taken_i = 1; br_target_i = 16'h0400;
    tick("R7");
    // R7: breakpoint at loop end overrides loop-back
    branch("R6", 'h0020);
    wr_cnt(4);
    wr_psw((1 << DB) | (1 << RP));
    step("R7");

    // R11: breakpoint address ignored when debug disabled
    branch("R6", 'h0020);
    wr_psw(1 << SM);
    step("R11");

    // R8: bus error wins over breakpoint
    branch("R6", 'h0020);
    wr_psw((1 << SM) | (1 << DB) | 'h00FF);
    step_i = 1; bus_err_i = 1;
    tick("R8");
    // R9: illegal instruction
    branch("R6", 'h0033);
    wr_psw('hF0FF);
    step_i = 1; ill_err_i = 1; br_taken_i = 1; br_target_i = 16'h0500;
    tick("R9");
    // R9: both events, bus vector taken
    wr_psw('h1234);
    step_i = 1; ill_err_i = 1; bus_err_i = 1;
    tick("R9");
    // R10: error signals without step have no effect
    bus_err_i = 1; ill_err_i = 1;
    tick("R10");

    // R2: wrap at top of address space
    branch("R6", 'hFFFF);
    step("R2");
    step("R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule